// File: doc/BRIEF.md
# Synchronous Burst Bus to Block RAM Bridge

This block lets a host's synchronous external memory bus read and write an on-chip block RAM. Everything, bus and RAM alike, runs on the bus clock. A transaction opens on the first rising edge where chip select is seen low. On that edge the bridge captures the start address. After a fixed initial latency of `DATA_LAT` clocks, one data beat moves on every edge, each to the next consecutive word. The host never states how long a burst is.

The end of a burst is inferred from the bus itself. The host keeps its control lines asserted for one extra clock after the last real beat, and only then raises chip select. The bridge therefore commits each write beat one edge late, once the following edge shows the burst still active. For reads it fetches each RAM word one edge ahead of the bus beat, which hides the RAM's one-cycle read latency. The trailing beat is dropped. Per-byte lane enables mask every write beat, so a one-beat burst can update a single byte.

The data pins are split into `data_in`, `data_out` and a pad enable `data_oe`, and the tristate buffer sits outside the block. Between bursts the host leaves chip select high for at least one edge. It may add further turnaround edges, and the bridge ignores the bus during all of them.

Top module: `sbus_bram_bridge`

## Requirements
- R1: `data_oe` is high exactly while both `cs_n` and `oe_n` are low. It is low in reset, during write bursts and during every turnaround cycle.
- R2: After at least one edge with `cs_n` high, the first edge with `cs_n` low captures `addr` as the start word of the burst.
- R3: A write burst of any length N of one or more beats stores beat j into word start+j. The first beat is sampled on the edge that comes `DATA_LAT` edges after the capture edge.
- R4: The trailing edge, where the controls are still low after beat N-1, writes nothing. Word start+N keeps its previous value.
- R5: On a write beat, `lane_n[0]` low enables bits 7:0 and `lane_n[1]` low enables bits 15:8. A byte whose lane is high keeps its old value.
- R6: Edges with `cs_n` high have no effect, whatever `we_n`, `oe_n`, `lane_n`, `addr` and `data_in` carry.
- R7: A read burst of any length presents word start+j on `data_out` before the edge `DATA_LAT`+j after capture. Bursts separated by a single idle edge work back to back.
- R8: Edges between the capture edge and the first data edge write nothing, even with `we_n` and all lanes low.
- R9: Burst addresses wrap from word 2^`ADDR_W`-1 to word 0.
- R10: Read bursts leave the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also clocks the RAM |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable (read) |
| we_n | input | 1 | Active-low write enable |
| lane_n | input | LANES | Active-low byte lane enables |
| addr | input | ADDR_W | Word address, used on the capture edge |
| data_in | input | 8*LANES | Write data from the bus pads |
| data_out | output | 8*LANES | Read data toward the bus pads |
| data_oe | output | 1 | Pad drive enable for `data_out` |

## Verification
The bound checker watches the cycle-level rules on every edge. It checks address capture, the one-word step per data edge, the return to idle after any edge with chip select high, the absence of pending beats during the latency, and the rule that every RAM write traces back to two chip-select-low edges with the matching lane mask. Only the bench's scenarios can show the data results. These are the correct words read back after bursts of many lengths and lane masks, an untouched neighbour word after the trailing beat, the wrap at the top of memory, and RAM left unchanged by turnaround garbage and by reads.

// File: rtl/sbb_pkg.sv
// Shared types for the synchronous burst bridge.
package sbb_pkg;
    // Burst phase as seen by the tracker.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LAT  = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/sbb_burst_track.sv
// Burst tracker: follows chip select through idle, latency and data
// phases, holds the word address of the beat due on the next edge and
// presents a one-word-ahead RAM read address.
// Assumes DATA_LAT >= 2 and at least one cs_n-high edge between bursts.
module sbb_burst_track
    import sbb_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    output phase_t            phase,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_stb,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int LAT_W = $clog2(DATA_LAT + 1);
    localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(DATA_LAT - 1);
    localparam logic [LAT_W-1:0] LAT_ONE  = LAT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [LAT_W-1:0] lat_cnt;

    // A data edge is any edge in the data phase with chip select low.
    always_comb beat_stb = (phase == PH_DATA) && !cs_n;

    // Fetch one word ahead during data so RAM latency is hidden.
    always_comb rd_addr = (phase == PH_DATA) ? beat_addr + ADDR_ONE : beat_addr;

    // Phase sequencing, latency counting and beat address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            lat_cnt   <= '0;
            beat_addr <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (!cs_n) begin
                        beat_addr <= addr;
                        lat_cnt   <= LAT_ONE;
                        phase     <= PH_LAT;
                    end
                end
                PH_LAT: begin
                    if (cs_n) begin
                        phase <= PH_IDLE;
                    end else if (lat_cnt == LAT_LAST) begin
                        phase <= PH_DATA;
                    end else begin
                        lat_cnt <= lat_cnt + LAT_ONE;
                    end
                end
                PH_DATA: begin
                    if (cs_n) begin
                        phase <= PH_IDLE;
                    end else begin
                        beat_addr <= beat_addr + ADDR_ONE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sbb_wr_commit.sv
// Write commit pipeline: holds each write beat for one edge and commits
// it only when the next edge still shows chip select low. The beat on the
// trailing edge is dropped when chip select rises.
// Assumes beat_stb comes from the burst tracker in the same clock domain.
module sbb_wr_commit #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 we_n,
    input  logic                 beat_stb,
    input  logic [ADDR_W-1:0]    beat_addr,
    input  logic [LANES-1:0]     lane_n,
    input  logic [8*LANES-1:0]   data_in,
    output logic                 pend_valid,
    output logic [LANES-1:0]     wr_be,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [8*LANES-1:0]   wr_data
);
    logic [LANES-1:0]   pend_be;
    logic [ADDR_W-1:0]  pend_addr;
    logic [8*LANES-1:0] pend_data;

    // Capture a candidate write beat on every data edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_be    <= '0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else begin
            pend_valid <= beat_stb && !we_n;
            pend_be    <= ~lane_n;
            pend_addr  <= beat_addr;
            pend_data  <= data_in;
        end
    end

    // Promote the candidate to a RAM write only if the burst continued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_be   <= '0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (pend_valid && !cs_n) begin
            wr_be   <= pend_be;
            wr_addr <= pend_addr;
            wr_data <= pend_data;
        end else begin
            wr_be <= '0;
        end
    end
endmodule

// File: rtl/sbb_ram.sv
// Single-port synchronous RAM with per-byte write enables and a
// registered, read-first output. Contents are not reset.
module sbb_ram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic                 clk,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [LANES-1:0]     be,
    input  logic [8*LANES-1:0]   wdata,
    output logic [8*LANES-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [DEPTH];

        // One byte column: optional write, registered read.
        always_ff @(posedge clk) begin
            if (be[g]) begin
                mem[addr] <= wdata[8*g +: 8];
            end
            rdata[8*g +: 8] <= mem[addr];
        end
    end
endmodule

// File: rtl/sbus_bram_bridge.sv
// Top of the bridge: the host's synchronous burst bus on one side and an
// internal block RAM on the other. Read data is driven through a pad
// enable while chip select and output enable are both low.
// Assumes one clock for bus and RAM, DATA_LAT >= 2, and at least one
// cs_n-high edge between bursts.
module sbus_bram_bridge
    import sbb_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int LANES    = 2,
    parameter int DATA_LAT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic [LANES-1:0]     lane_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [8*LANES-1:0]   data_in,
    output logic [8*LANES-1:0]   data_out,
    output logic                 data_oe
);
    localparam int DATA_W = 8 * LANES;

    phase_t              phase;
    logic [ADDR_W-1:0]   beat_addr;
    logic                beat_stb;
    logic [ADDR_W-1:0]   rd_addr;
    logic                pend_valid;
    logic [LANES-1:0]    wr_be;
    logic [ADDR_W-1:0]   wr_addr;
    logic [DATA_W-1:0]   wr_data;
    logic [ADDR_W-1:0]   ram_addr;
    logic [DATA_W-1:0]   ram_rdata;

    sbb_burst_track #(
        .ADDR_W   (ADDR_W),
        .DATA_LAT (DATA_LAT)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .addr      (addr),
        .phase     (phase),
        .beat_addr (beat_addr),
        .beat_stb  (beat_stb),
        .rd_addr   (rd_addr)
    );

    sbb_wr_commit #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .we_n       (we_n),
        .beat_stb   (beat_stb),
        .beat_addr  (beat_addr),
        .lane_n     (lane_n),
        .data_in    (data_in),
        .pend_valid (pend_valid),
        .wr_be      (wr_be),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    // Single RAM port: a committed write takes priority over prefetch.
    always_comb ram_addr = (|wr_be) ? wr_addr : rd_addr;

    sbb_ram #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ram (
        .clk   (clk),
        .addr  (ram_addr),
        .be    (wr_be),
        .wdata (wr_data),
        .rdata (ram_rdata)
    );

    // Pad drive: only while the host selects and reads.
    always_comb begin
        data_out = ram_rdata;
        data_oe  = !cs_n && !oe_n;
    end
endmodule

// File: rtl/sbus_bram_bridge_chk.sv
// Checker for the bridge: cycle rules on phase, address and commits.
module sbus_bram_bridge_chk
    import sbb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic [LANES-1:0]  lane_n,
    input logic [ADDR_W-1:0] addr,
    input phase_t            phase,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              pend_valid,
    input logic [LANES-1:0]  wr_be
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    // R2
    capture_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !cs_n) |=> (beat_addr == $past(addr)));

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && !cs_n) |=> (beat_addr == $past(beat_addr) + STEP));

    // R6
    idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase == PH_IDLE));

    // R8
    no_early_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_DATA) |=> !pend_valid);

    // R4
    commit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_be) |-> ($past(!cs_n) && $past(!cs_n, 2) && $past(!we_n, 2)));

    // R5
    lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_be) |-> (wr_be == ~$past(lane_n, 2)));
endmodule

bind sbus_bram_bridge sbus_bram_bridge_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .lane_n     (lane_n),
    .addr       (addr),
    .phase      (phase),
    .beat_addr  (beat_addr),
    .pend_valid (pend_valid),
    .wr_be      (wr_be)
);

// File: tb/tb_sbus_bram_bridge.sv
module tb_sbus_bram_bridge;
    localparam int AW    = 6;
    localparam int LN    = 2;
    localparam int DW    = 8 * LN;
    localparam int LAT   = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [LN-1:0] lane_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int seed = 1;
    logic [DW-1:0] mdl [DEPTH];

    always #10 clk = ~clk;

    sbus_bram_bridge #(
        .ADDR_W   (AW),
        .LANES    (LN),
        .DATA_LAT (LAT)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .lane_n   (lane_n),
        .addr     (addr),
        .data_in  (data_in),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Turnaround edges: chip select high, every other line toggled (R6).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cs_n = 1'b1; oe_n = 1'b0; we_n = 1'b0; lane_n = '0;
            addr = AW'($urandom); data_in = DW'($urandom);
            #1 check(data_oe == 1'b0, "R1", DW'(data_oe), '0);
        end
    endtask

    task automatic wr_burst(input int start, input int n, input logic [LN-1:0] msk);
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(start);
        lane_n = '0; data_in = 16'hDEAD;
        // Latency edges carry garbage with all lanes on (R8).
        for (int k = 1; k < LAT; k++) begin
            @(negedge clk);
            data_in = 16'hDEAD; lane_n = '0; addr = AW'($urandom);
        end
        for (int j = 0; j < n; j++) begin
            logic [DW-1:0] v;
            int idx;
            v = DW'(seed * 16'h3b1 ^ j * 16'h1357);
            idx = (start + j) % DEPTH;
            @(negedge clk);
            data_in = v; lane_n = msk;
            for (int b = 0; b < LN; b++)
                if (!msk[b]) mdl[idx][8*b +: 8] = v[8*b +: 8];
            #1 check(data_oe == 1'b0, "R1", DW'(data_oe), '0);
        end
        seed++;
        // Trailing edge: controls still low, all lanes on (R4).
        @(negedge clk);
        data_in = 16'hBEEF; lane_n = '0;
        idle(1);
    endtask

    task automatic rd_burst(input int start, input int n, input string req);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(start); lane_n = '0;
        for (int k = 1; k < LAT; k++) begin
            @(negedge clk);
            addr = AW'($urandom);
        end
        for (int j = 0; j < n; j++) begin
            logic [DW-1:0] e;
            @(negedge clk);
            #1;
            e = mdl[(start + j) % DEPTH];
            check(data_oe && (data_out === e), req, data_out, e);
        end
        @(negedge clk);
        idle(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 check(data_oe == 1'b0, "R1", DW'(data_oe), '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // Fill every word with one long burst; trailing edge wraps onto word 0.
        wr_burst(0, DEPTH, 2'b00);
        rd_burst(0, DEPTH, "R7");

        // Sweep burst lengths and lane masks, reading neighbours back.
        for (int n = 1; n <= 6; n++) begin
            for (int m = 0; m < 3; m++) begin
                int s;
                logic [LN-1:0] msk;
                s = (n * 11 + m * 5) % DEPTH;
                msk = LN'(m);
                wr_burst(s, n, msk);
                idle(n % 3);
                if (m == 0) rd_burst(s, n, "R3");
                else rd_burst(s, n, "R5");
                rd_burst((s + n) % DEPTH, 1, "R4");
                rd_burst((s + DEPTH - 1) % DEPTH, 1, "R4");
            end
        end

        // Start address capture at spread-out words.
        for (int s = 0; s < DEPTH; s += 9) rd_burst(s, 1, "R2");

        // Latency edges must not write.
        wr_burst(20, 1, 2'b00);
        rd_burst(18, 5, "R8");

        // Wrap at the top of memory.
        wr_burst(62, 4, 2'b00);
        rd_burst(61, 6, "R9");

        // Reads leave memory unchanged.
        rd_burst(10, 8, "R10");
        rd_burst(8, 12, "R10");

        // Long turnaround with garbage, then a full comparison.
        idle(7);
        rd_burst(0, DEPTH, "R6");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule